// File: doc/BRIEF.md
# Video Memory Address Counter

This block keeps the 24-bit start address of the displayed picture and the running address from which a raster display controller fetches pixel data. A processor reaches it through a small byte/word register port. The start address is loaded one byte at a time. The live fetch address can be read and patched one byte at a time. Two word-count registers set the distance between lines.

Display timing comes from elsewhere as single-cycle strobes. A line strobe moves the fetch address forward by the line width plus the line offset. A frame strobe sends it back to the start address. A vertical frequency counter also lives here. It steps on every line strobe and on every processor read of it, and the frame strobe clears it.

Top module: `vid_addr_counter`

## Requirements
- R1: With `cpu_wr` high, select codes 0, 1 and 2 write `cpu_wdata[7:0]` into the low, middle and high byte of the start address, which appears on `base_addr` one cycle later.
- R2: A write to the high (code 2) or middle (code 1) start-address byte also sets the low start-address byte to zero in the same cycle.
- R3: A frame strobe (`vblank`) loads `fetch_addr` from `base_addr` and clears the vertical frequency counter to zero.
- R4: A line strobe (`hblank`) adds the line width (bits 9:0 of the width register) plus the line offset (bits 8:0 of the offset register) to `fetch_addr`.
- R5: Select codes 3, 4 and 5 read the low, middle and high byte of `fetch_addr` on `cpu_rdata[7:0]`. A write to one of them replaces only that byte and keeps the other two.
- R6: Code 6 is the line offset register and code 7 is the line width register. A read of code 6 returns bits 8:0 of the offset and zero in bits 15:9. A read of code 7 returns all 16 stored bits.
- R7: A read of code 8 returns the vertical frequency counter and then increments it by one. Each line strobe also increments it. A write to code 8 has no effect.
- R8: In any cycle, a processor write to a fetch-address byte takes priority over both strobes. A frame strobe takes priority over a line strobe.
- R9: `fetch_addr` wraps modulo 2^24 when a line advance passes the top of the address range.
- R10: A synchronous reset with `rst_n` low clears the start address, fetch address, line width, line offset and vertical frequency counter to zero. Unused select codes read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (steps the frequency counter on code 8) |
| cpu_sel | input | 4 | Register select code |
| cpu_wdata | input | 16 | Write data |
| cpu_rdata | output | 16 | Read data for the selected register, combinational |
| hblank | input | 1 | Line strobe, one cycle per line |
| vblank | input | 1 | Frame strobe, one cycle per frame |
| fetch_addr | output | 24 | Live fetch address |
| base_addr | output | 24 | Start address of the picture |

## Verification
The collision of interest is a processor patch of a fetch-address byte landing in the same cycle as a line or frame strobe. The bench forces this by asserting `cpu_wr` on a counter byte together with `hblank` in one vector and together with `vblank` in another. It then checks that the new address holds exactly the written byte over the untouched old bytes, with no advance and no reload. It also raises both strobes together to confirm that the reload wins over the advance. Separately, it provokes a read of the frequency counter against its clear.

// File: rtl/vac_pkg.sv
// Package: shared widths and helpers for the video address counter.
// Assumes byte-granular register access on the low data byte.
package vac_pkg;
    localparam int VAC_ADDR_W  = 24;
    localparam int VAC_DATA_W  = 16;
    localparam int VAC_SEL_W   = 4;
    localparam int VAC_WIDTH_B = 10;
    localparam int VAC_OFFS_B  = 9;
    localparam int VAC_VFC_W   = 16;

    // Register select map, derived from the number of address bytes.
    function automatic int sel_base(input int lane);
        return lane;
    endfunction
    function automatic int sel_cnt(input int nbytes, input int lane);
        return nbytes + lane;
    endfunction
    function automatic int sel_offs(input int nbytes);
        return 2 * nbytes;
    endfunction
    function automatic int sel_width(input int nbytes);
        return 2 * nbytes + 1;
    endfunction
    function automatic int sel_vfc(input int nbytes);
        return 2 * nbytes + 2;
    endfunction
endpackage

// File: rtl/vac_base_reg.sv
// Start-address register, written one byte lane at a time.
// Assumes at most one lane enable per cycle. A write to any lane above
// the lowest also zeroes the lowest lane.
module vac_base_reg #(
    parameter int ADDR_W = 24,
    localparam int NB    = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     lane_we,
    input  logic [7:0]        wbyte,
    output logic [ADDR_W-1:0] base_q
);
    logic upper_we;

    // Any write above lane 0 clears lane 0.
    always_comb begin
        upper_we = |(lane_we >> 1);
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        if (i == 0) begin : g_low
            // Lowest lane: direct write, else cleared by an upper-lane write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q[7:0] <= '0;
                else if (lane_we[0])
                    base_q[7:0] <= wbyte;
                else if (upper_we)
                    base_q[7:0] <= '0;
            end
        end else begin : g_up
            // Upper lanes: plain byte write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    base_q[8*i +: 8] <= '0;
                else if (lane_we[i])
                    base_q[8*i +: 8] <= wbyte;
            end
        end
    end
endmodule

// File: rtl/vac_line_regs.sv
// Line width and line offset registers, in words.
// Width keeps the full data word. Offset keeps only its significant bits.
module vac_line_regs #(
    parameter int DATA_W = 16,
    parameter int OFFS_B = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              width_we,
    input  logic              offs_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] width_q,
    output logic [OFFS_B-1:0] offs_q
);
    // Width register write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            width_q <= '0;
        else if (width_we)
            width_q <= wdata;
    end

    // Offset register write, masked to its field.
    always_ff @(posedge clk) begin
        if (!rst_n)
            offs_q <= '0;
        else if (offs_we)
            offs_q <= wdata[OFFS_B-1:0];
    end
endmodule

// File: rtl/vac_fetch_ctr.sv
// Live fetch address counter.
// Priority per cycle: processor byte write, then frame reload, then line
// advance. A write to one lane holds the other lanes. Addition wraps at
// 2^ADDR_W.
module vac_fetch_ctr #(
    parameter int ADDR_W = 24,
    localparam int NB    = ADDR_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NB-1:0]     lane_we,
    input  logic [7:0]        wbyte,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] step,
    input  logic              hblank,
    input  logic              vblank,
    output logic [ADDR_W-1:0] fetch_q
);
    logic              any_we;
    logic [ADDR_W-1:0] advanced;

    // Shared terms: write-hit flag and the wrapped next-line address.
    always_comb begin
        any_we   = |lane_we;
        advanced = fetch_q + step;
    end

    for (genvar i = 0; i < NB; i++) begin : g_lane
        // One byte lane of the counter with the priority chain.
        always_ff @(posedge clk) begin
            if (!rst_n)
                fetch_q[8*i +: 8] <= '0;
            else if (any_we) begin
                if (lane_we[i])
                    fetch_q[8*i +: 8] <= wbyte;
            end else if (vblank)
                fetch_q[8*i +: 8] <= base[8*i +: 8];
            else if (hblank)
                fetch_q[8*i +: 8] <= advanced[8*i +: 8];
        end
    end
endmodule

// File: rtl/vac_vfc.sv
// Vertical frequency counter. The frame strobe clears it. A read and a
// line strobe each add one, so both together add two. Wraps at 2^VFC_W.
module vac_vfc #(
    parameter int VFC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_hit,
    input  logic             hblank,
    input  logic             vblank,
    output logic [VFC_W-1:0] vfc_q
);
    logic [1:0] incr;

    // Number of steps requested this cycle.
    always_comb begin
        incr = {1'b0, rd_hit} + {1'b0, hblank};
    end

    // Counter update with frame clear taking priority.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vfc_q <= '0;
        else if (vblank)
            vfc_q <= '0;
        else
            vfc_q <= vfc_q + VFC_W'(incr);
    end
endmodule

// File: rtl/vid_addr_counter.sv
// Video memory address counter top. It decodes the register port, forms
// the line step (width + offset) and muxes read data.
// Assumes single-cycle strobes and ADDR_W a multiple of 8.
module vid_addr_counter
    import vac_pkg::*;
#(
    parameter int ADDR_W  = VAC_ADDR_W,
    parameter int DATA_W  = VAC_DATA_W,
    parameter int SEL_W   = VAC_SEL_W,
    parameter int WIDTH_B = VAC_WIDTH_B,
    parameter int OFFS_B  = VAC_OFFS_B,
    parameter int VFC_W   = VAC_VFC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_wr,
    input  logic              cpu_rd,
    input  logic [SEL_W-1:0]  cpu_sel,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              hblank,
    input  logic              vblank,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [ADDR_W-1:0] base_addr
);
    localparam int NB        = ADDR_W / 8;
    localparam int SEL_OFFS  = sel_offs(NB);
    localparam int SEL_WIDTH = sel_width(NB);
    localparam int SEL_VFC   = sel_vfc(NB);

    logic [NB-1:0]     base_we;
    logic [NB-1:0]     cnt_we;
    logic [DATA_W-1:0] line_width;
    logic [OFFS_B-1:0] line_offs;
    logic [VFC_W-1:0]  vfc_val;
    logic [ADDR_W-1:0] line_step;
    logic              vfc_rd;

    // Per-lane write decode for start address and counter.
    for (genvar i = 0; i < NB; i++) begin : g_dec
        assign base_we[i] = cpu_wr && (cpu_sel == SEL_W'(sel_base(i)));
        assign cnt_we[i]  = cpu_wr && (cpu_sel == SEL_W'(sel_cnt(NB, i)));
    end

    // Read hit on the frequency counter, and the per-line step.
    always_comb begin
        vfc_rd    = cpu_rd && (cpu_sel == SEL_W'(SEL_VFC));
        line_step = ADDR_W'(line_width[WIDTH_B-1:0]) + ADDR_W'(line_offs);
    end

    vac_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (base_we),
        .wbyte   (cpu_wdata[7:0]),
        .base_q  (base_addr)
    );

    vac_line_regs #(.DATA_W(DATA_W), .OFFS_B(OFFS_B)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .width_we (cpu_wr && (cpu_sel == SEL_W'(SEL_WIDTH))),
        .offs_we  (cpu_wr && (cpu_sel == SEL_W'(SEL_OFFS))),
        .wdata    (cpu_wdata),
        .width_q  (line_width),
        .offs_q   (line_offs)
    );

    vac_fetch_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .lane_we (cnt_we),
        .wbyte   (cpu_wdata[7:0]),
        .base    (base_addr),
        .step    (line_step),
        .hblank  (hblank),
        .vblank  (vblank),
        .fetch_q (fetch_addr)
    );

    vac_vfc #(.VFC_W(VFC_W)) u_vfc (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_hit (vfc_rd),
        .hblank (hblank),
        .vblank (vblank),
        .vfc_q  (vfc_val)
    );

    // Read data multiplexer; unused codes return zero.
    always_comb begin
        cpu_rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (cpu_sel == SEL_W'(sel_base(i)))
                cpu_rdata = DATA_W'(base_addr[8*i +: 8]);
            if (cpu_sel == SEL_W'(sel_cnt(NB, i)))
                cpu_rdata = DATA_W'(fetch_addr[8*i +: 8]);
        end
        if (cpu_sel == SEL_W'(SEL_OFFS))
            cpu_rdata = DATA_W'(line_offs);
        if (cpu_sel == SEL_W'(SEL_WIDTH))
            cpu_rdata = line_width;
        if (cpu_sel == SEL_W'(SEL_VFC))
            cpu_rdata = DATA_W'(vfc_val);
    end
endmodule

// File: rtl/vac_checker.sv
// Temporal checks for the video address counter, bound to the top.
// Assumes the select map from vac_pkg.
module vac_checker
    import vac_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int DATA_W  = 16,
    parameter int SEL_W   = 4,
    parameter int WIDTH_B = 10,
    parameter int OFFS_B  = 9,
    parameter int VFC_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_wr,
    input logic              cpu_rd,
    input logic [SEL_W-1:0]  cpu_sel,
    input logic              hblank,
    input logic              vblank,
    input logic [ADDR_W-1:0] fetch_addr,
    input logic [ADDR_W-1:0] base_addr,
    input logic [DATA_W-1:0] line_width,
    input logic [OFFS_B-1:0] line_offs,
    input logic [VFC_W-1:0]  vfc_val
);
    localparam int NB = ADDR_W / 8;

    logic              cnt_wr;
    logic              upper_base_wr;
    logic              low_cnt_wr;
    logic [ADDR_W-1:0] chk_step;

    // Observed stimulus classes.
    always_comb begin
        cnt_wr        = cpu_wr && (cpu_sel >= SEL_W'(sel_cnt(NB, 0)))
                               && (cpu_sel <= SEL_W'(sel_cnt(NB, NB - 1)));
        upper_base_wr = cpu_wr && (cpu_sel >= SEL_W'(sel_base(1)))
                               && (cpu_sel <= SEL_W'(sel_base(NB - 1)));
        low_cnt_wr    = cpu_wr && (cpu_sel == SEL_W'(sel_cnt(NB, 0)));
        chk_step      = ADDR_W'(line_width[WIDTH_B-1:0]) + ADDR_W'(line_offs);
    end

    AST_FRAME_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (vblank && !cnt_wr) |=> fetch_addr == $past(base_addr)); // R3
    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (hblank && !vblank && !cnt_wr) |=> fetch_addr == ADDR_W'($past(fetch_addr) + $past(chk_step))); // R4
    AST_LOW_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        upper_base_wr |=> base_addr[7:0] == 8'h00); // R2
    AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        low_cnt_wr |=> $stable(fetch_addr[ADDR_W-1:8])); // R5
    AST_VFC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        vblank |=> vfc_val == '0); // R3
    AST_VFC_READ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && cpu_sel == SEL_W'(sel_vfc(NB)) && !vblank && !hblank)
        |=> vfc_val == VFC_W'($past(vfc_val) + 1'b1)); // R7
endmodule

bind vid_addr_counter vac_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
    .WIDTH_B(WIDTH_B), .OFFS_B(OFFS_B), .VFC_W(VFC_W)
) u_vac_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_wr     (cpu_wr),
    .cpu_rd     (cpu_rd),
    .cpu_sel    (cpu_sel),
    .hblank     (hblank),
    .vblank     (vblank),
    .fetch_addr (fetch_addr),
    .base_addr  (base_addr),
    .line_width (line_width),
    .line_offs  (line_offs),
    .vfc_val    (vfc_val)
);

// File: tb/sim_vid_addr_counter.sv
module sim_vid_addr_counter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic        cpu_rd = 1'b0;
    logic [3:0]  cpu_sel = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        hblank = 1'b0;
    logic        vblank = 1'b0;
    logic [23:0] fetch_addr;
    logic [23:0] base_addr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    vid_addr_counter u0 (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_rd(cpu_rd),
        .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .hblank(hblank), .vblank(vblank),
        .fetch_addr(fetch_addr), .base_addr(base_addr)
    );

    typedef struct packed {
        logic        wr;
        logic        hbl;
        logic        vbl;
        logic [3:0]  sel;
        logic [15:0] wd;
        logic [23:0] ef;
        logic [23:0] eb;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 4'd2, 16'h0012, 24'h000000, 24'h120000}, // R1 high
        '{1'b1, 1'b0, 1'b0, 4'd1, 16'h0034, 24'h000000, 24'h123400}, // R1 mid
        '{1'b1, 1'b0, 1'b0, 4'd0, 16'h0056, 24'h000000, 24'h123456}, // R1 low
        '{1'b1, 1'b0, 1'b0, 4'd1, 16'h0078, 24'h000000, 24'h127800}, // R2
        '{1'b1, 1'b0, 1'b0, 4'd0, 16'h009A, 24'h000000, 24'h12789A}, // R1
        '{1'b0, 1'b0, 1'b1, 4'd0, 16'h0000, 24'h12789A, 24'h12789A}, // R3
        '{1'b1, 1'b0, 1'b0, 4'd7, 16'h0050, 24'h12789A, 24'h12789A}, // R6 width
        '{1'b1, 1'b0, 1'b0, 4'd6, 16'h0010, 24'h12789A, 24'h12789A}, // R6 offset
        '{1'b0, 1'b1, 1'b0, 4'd0, 16'h0000, 24'h1278FA, 24'h12789A}, // R4
        '{1'b0, 1'b1, 1'b0, 4'd0, 16'h0000, 24'h12795A, 24'h12789A}, // R4
        '{1'b1, 1'b0, 1'b0, 4'd7, 16'hFC28, 24'h12795A, 24'h12789A}, // R4 masked width
        '{1'b1, 1'b0, 1'b0, 4'd6, 16'hFE03, 24'h12795A, 24'h12789A}, // R4 masked offset
        '{1'b0, 1'b1, 1'b0, 4'd0, 16'h0000, 24'h127985, 24'h12789A}, // R4 step 0x2B
        '{1'b1, 1'b0, 1'b0, 4'd4, 16'h00AB, 24'h12AB85, 24'h12789A}, // R5
        '{1'b1, 1'b1, 1'b0, 4'd5, 16'h0003, 24'h03AB85, 24'h12789A}, // R8 write beats line
        '{1'b1, 1'b0, 1'b1, 4'd3, 16'h0011, 24'h03AB11, 24'h12789A}, // R8 write beats frame
        '{1'b0, 1'b1, 1'b1, 4'd0, 16'h0000, 24'h12789A, 24'h12789A}, // R8 frame beats line
        '{1'b1, 1'b0, 1'b0, 4'd2, 16'h00FF, 24'h12789A, 24'hFF7800}, // R2 via high
        '{1'b1, 1'b0, 1'b0, 4'd1, 16'h00FF, 24'h12789A, 24'hFFFF00}, // R1
        '{1'b1, 1'b0, 1'b0, 4'd0, 16'h00F0, 24'h12789A, 24'hFFFFF0}, // R1
        '{1'b0, 1'b0, 1'b1, 4'd0, 16'h0000, 24'hFFFFF0, 24'hFFFFF0}, // R3
        '{1'b0, 1'b1, 1'b0, 4'd0, 16'h0000, 24'h00001B, 24'hFFFFF0}  // R9 wrap
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        cpu_wr = 1'b0; cpu_rd = 1'b0; hblank = 1'b0; vblank = 1'b0;
        cpu_sel = '0; cpu_wdata = '0;
    endtask

    // One-cycle operation: drive at negedge, let one edge pass, return at negedge.
    task automatic step(input logic wr, input logic rd, input logic [3:0] sel,
                        input logic [15:0] wd, input logic hb, input logic vb);
        cpu_wr = wr; cpu_rd = rd; cpu_sel = sel; cpu_wdata = wd;
        hblank = hb; vblank = vb;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    // Combinational read sampled before the edge; the edge then applies side effects.
    task automatic rd_reg(input logic [3:0] sel, output logic [15:0] val);
        cpu_rd = 1'b1; cpu_sel = sel;
        #1 val = cpu_rdata;
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        idle();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10 reset state
        chk("R10 fetch", 32'(fetch_addr), 32'h0);
        chk("R10 base", 32'(base_addr), 32'h0);
        rd_reg(4'd7, rv); chk("R10 width", 32'(rv), 32'h0);
        rd_reg(4'd6, rv); chk("R10 offset", 32'(rv), 32'h0);

        // Vector table walk
        for (int i = 0; i < NV; i++) begin
            step(VEC[i].wr, 1'b0, VEC[i].sel, VEC[i].wd, VEC[i].hbl, VEC[i].vbl);
            chk($sformatf("vec%0d fetch R1-side", i), 32'(fetch_addr), 32'(VEC[i].ef));
            chk($sformatf("vec%0d base", i), 32'(base_addr), 32'(VEC[i].eb));
        end

        // R5 counter bytes read back; fetch is 0x00001B
        rd_reg(4'd3, rv); chk("R5 cnt lo read", 32'(rv), 32'h1B);
        rd_reg(4'd5, rv); chk("R5 cnt hi read", 32'(rv), 32'h00);
        rd_reg(4'd2, rv); chk("R1 base hi read", 32'(rv), 32'hFF);

        // R6 readback masking
        step(1'b1, 1'b0, 4'd6, 16'hFFFF, 1'b0, 1'b0);
        rd_reg(4'd6, rv); chk("R6 offset read", 32'(rv), 32'h01FF);
        rd_reg(4'd7, rv); chk("R6 width read", 32'(rv), 32'hFC28);
        rd_reg(4'd12, rv); chk("R10 unused code", 32'(rv), 32'h0);

        // R7 / R3 vertical frequency counter
        step(1'b0, 1'b0, 4'd0, 16'h0, 1'b0, 1'b1);
        rd_reg(4'd8, rv); chk("R3 vfc cleared", 32'(rv), 32'h0);
        rd_reg(4'd8, rv); chk("R7 read increments", 32'(rv), 32'h1);
        step(1'b0, 1'b0, 4'd0, 16'h0, 1'b1, 1'b0);
        rd_reg(4'd8, rv); chk("R7 line increments", 32'(rv), 32'h3);
        step(1'b1, 1'b0, 4'd8, 16'h1234, 1'b0, 1'b0);
        rd_reg(4'd8, rv); chk("R7 write ignored", 32'(rv), 32'h4);
        step(1'b0, 1'b1, 4'd8, 16'h0, 1'b0, 1'b1); // R8 read against frame clear
        rd_reg(4'd8, rv); chk("R3 clear beats read", 32'(rv), 32'h0);

        // R10 reset in the middle of operation
        step(1'b1, 1'b0, 4'd4, 16'h0055, 1'b0, 1'b0);
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R10 fetch after reset", 32'(fetch_addr), 32'h0);
        chk("R10 base after reset", 32'(base_addr), 32'h0);
        rd_reg(4'd8, rv); chk("R10 vfc after reset", 32'(rv), 32'h0);
        rd_reg(4'd7, rv); chk("R10 width after reset", 32'(rv), 32'h0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule